// File: doc/BRIEF.md
# Framed Synchronous Serial Slave Port

This block is the slave end of a four-wire synchronous serial link. An external master owns the bit clock and the frame marker; the port only listens to those two, samples a receive line, and drives a single transmit line. Each frame is one 16-bit word moved most-significant bit first, and both directions run in the same frame, so a word can leave and another arrive at once.

Inside the chip the master's bit clock is not used as a clock. A separate synchronizer turns each bit period into a one-cycle enable `bitEn` in the system clock domain, and the port does all of its work on the cycles where that enable is high. Words to send are offered on a valid/ready input and taken only at the start of a frame; received words leave on a data bus with a one-cycle valid strobe. If nothing is offered when a frame starts, zeros go out and a one-cycle underrun flag is raised. A frame marker that arrives early throws away the half-received word and starts over.

Top module: `framed_serial_slave`

## Requirements
- R1: While and right after reset, `txBit`, `rxValid`, `underrun` and `txReady` are all 0.
- R2: `txReady` is 1 only in a cycle where `bitEn` and `frameSync` are both 1; if `txValid` is 1 in that cycle the word on `txData` is taken and `underrun` stays 0.
- R3: The taken word is sent most-significant bit first: after the beat that carries the frame marker `txBit` shows bit 15, and after the k-th following beat it shows bit 15-k.
- R4: The `rxBit` value sampled on the frame-marker beat is bit 15 of the received word and the one on the 15th following beat is bit 0; in the cycle after that last beat `rxValid` is 1 for exactly one cycle and `rxData` holds the word.
- R5: If `txValid` is 0 on a frame-marker beat, the frame sends all zeros and `underrun` is 1 for the one cycle after that beat.
- R6: A frame marker that arrives before 16 bits of the current word have been sampled discards the partial word (no `rxValid` for it) and starts a new word in both directions from that beat.
- R7: Once 16 bits have been moved and no new frame marker has come, `txBit` is 0 and `rxBit` is ignored (no `rxValid`) until the next marker.
- R8: In cycles where `bitEn` is 0, `frameSync` and `rxBit` have no effect and `txBit` keeps its value.
- R9: Frames may follow each other with no gap: a marker on the beat right after the 16th bit starts the next word, and every such word is sent and received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per master bit period |
| frameSync | input | 1 | Frame marker from the master, valid with `bitEn` |
| rxBit | input | 1 | Serial data from the master |
| txBit | output | 1 | Serial data to the master |
| txData | input | 16 | Word offered for sending |
| txValid | input | 1 | `txData` holds a word to send |
| txReady | output | 1 | Port takes the offered word in this cycle |
| rxData | output | 16 | Last complete received word |
| rxValid | output | 1 | One-cycle strobe for a new `rxData` |
| underrun | output | 1 | One-cycle flag: a frame started with no word offered |

## Verification
The assertions assume that `bitEn` is never high in two cycles back to back only in the sense that a frame cannot finish twice without a beat in between, and that `frameSync` is only meaningful alongside `bitEn`. The stimulus raises `bitEn` on every second cycle and changes `frameSync`, `rxBit`, `txData` and `txValid` only on falling clock edges, so each beat sees settled inputs. The directed tests deliberately hold `frameSync` high on cycles without `bitEn` to show such values are ignored, which the assertions tolerate because they only tie state changes to beats.

// File: rtl/fssp_pkg.sv
package fssp_pkg;

  typedef struct packed {
    logic loadWord;   // frame start, word offered
    logic loadIdle;   // frame start, nothing offered
    logic shiftTx;    // advance transmit register
    logic startRx;    // first receive bit of a frame
    logic shiftRx;    // middle receive bit
    logic finishRx;   // last receive bit, publish word
  } fssp_strobe_t;

endpackage

// File: rtl/fssp_ctrl.sv
module fssp_ctrl
  import fssp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitEn,
  input  logic         frameSync,
  input  logic         txValid,
  output logic         txReady,
  output fssp_strobe_t strb
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic             active;
  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    strb    = '0;
    txReady = bitEn & frameSync;
    if (bitEn) begin
      if (frameSync) begin
        strb.loadWord = txValid;
        strb.loadIdle = ~txValid;
        strb.startRx  = 1'b1;
      end else begin
        strb.shiftTx = 1'b1;
        if (active) begin
          if (bitIdx == LAST_IDX) strb.finishRx = 1'b1;
          else                    strb.shiftRx  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitIdx <= '0;
    end else if (bitEn) begin
      if (frameSync) begin
        active <= 1'b1;
        bitIdx <= IDX_W'(1);
      end else if (active) begin
        if (bitIdx == LAST_IDX) active <= 1'b0;
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  AST_ACTIVE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitIdx != '0)); // R6

endmodule

// File: rtl/fssp_datapath.sv
module fssp_datapath
  import fssp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fssp_strobe_t      strb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              rxBit,
  output logic              txBit,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  output logic              underrun
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.loadWord) begin
      txShift <= txWord;
    end else if (strb.loadIdle) begin
      txShift <= '0;
    end else if (strb.shiftTx) begin
      txShift <= {txShift[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      rxValid  <= strb.finishRx;
      underrun <= strb.loadIdle;
      if (strb.startRx) begin
        rxShift <= {{(WORD_W-1){1'b0}}, rxBit};
      end else if (strb.shiftRx) begin
        rxShift <= {rxShift[WORD_W-2:0], rxBit};
      end
      if (strb.finishRx) begin
        rxData <= {rxShift[WORD_W-2:0], rxBit};
      end
    end
  end

  assign txBit = txShift[WORD_W-1];

  AST_RXVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R4

  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !txBit); // R5

endmodule

// File: rtl/framed_serial_slave.sv
module framed_serial_slave
  import fssp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameSync,
  input  logic              rxBit,
  output logic              txBit,
  input  logic [WORD_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [WORD_W-1:0] rxData,
  output logic              rxValid,
  output logic              underrun
);

  fssp_strobe_t strb;

  fssp_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .frameSync (frameSync),
    .txValid   (txValid),
    .txReady   (txReady),
    .strb      (strb)
  );

  fssp_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .txWord   (txData),
    .rxBit    (rxBit),
    .txBit    (txBit),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .underrun (underrun)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit)); // R8

  AST_RXVALID_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(bitEn)); // R4

  AST_ACCEPT_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && txValid) |=> !underrun); // R2

endmodule

// File: tb/framed_serial_slave_test.sv
module framed_serial_slave_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        frameSync = 1'b0;
  logic        rxBit = 1'b0;
  logic        txBit;
  logic [15:0] txData = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [15:0] rxData;
  logic        rxValid;
  logic        underrun;

  int nChecks = 0;
  int nFail = 0;
  logic readySeen;

  always #2 clk = ~clk;

  framed_serial_slave uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameSync(frameSync),
    .rxBit(rxBit), .txBit(txBit), .txData(txData), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxValid(rxValid), .underrun(underrun)
  );

  // {txValid, txWord, rxWord}
  localparam logic [32:0] VEC [0:4] = '{
    {1'b1, 16'hA5C3, 16'h1234},
    {1'b1, 16'hFFFF, 16'h8001},
    {1'b0, 16'h7E7E, 16'hBEEF},
    {1'b1, 16'h0001, 16'hFFFF},
    {1'b1, 16'h8000, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doBeat(input logic sync, input logic rx);
    @(negedge clk);
    bitEn = 1'b1;
    frameSync = sync;
    rxBit = rx;
    #1 readySeen = txReady;
    @(negedge clk);
    bitEn = 1'b0;
    frameSync = 1'b0;
  endtask

  task automatic runWord(input logic txv, input logic [15:0] txw, input logic [15:0] rxw,
                         output logic [15:0] txCap, output logic [15:0] rxGot,
                         output logic gotValid, output logic earlyValid,
                         output logic urun, output logic rdy);
    txValid = txv;
    txData = txw;
    earlyValid = 1'b0;
    gotValid = 1'b0;
    rxGot = '0;
    urun = 1'b0;
    rdy = 1'b0;
    for (int k = 0; k < 16; k++) begin
      doBeat(k == 0, rxw[15-k]);
      if (k == 0) begin
        urun = underrun;
        rdy = readySeen;
        txValid = 1'b0;
      end
      txCap[15-k] = txBit;
      if (k < 15 && rxValid) earlyValid = 1'b1;
      if (k == 15) begin
        gotValid = rxValid;
        rxGot = rxData;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] txCap, rxGot;
    logic gotValid, earlyValid, urun, rdy, bad;

    repeat (3) @(negedge clk);
    chk(txBit == 0 && rxValid == 0 && underrun == 0 && txReady == 0, "R1 in reset",
        {txBit, rxValid, underrun, txReady}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(txBit == 0 && rxValid == 0 && underrun == 0 && txReady == 0, "R1 after reset",
        {txBit, rxValid, underrun, txReady}, 0);

    // back-to-back frames from the vector table (R9)
    for (int i = 0; i < 5; i++) begin
      runWord(VEC[i][32], VEC[i][31:16], VEC[i][15:0], txCap, rxGot, gotValid, earlyValid, urun, rdy);
      chk(txCap == (VEC[i][32] ? VEC[i][31:16] : 16'h0), "R3/R9 tx word", txCap,
          VEC[i][32] ? VEC[i][31:16] : 16'h0);
      chk(gotValid && rxGot == VEC[i][15:0] && !earlyValid, "R4/R9 rx word",
          {earlyValid, gotValid, rxGot}, {2'b01, VEC[i][15:0]});
      chk(urun == !VEC[i][32], "R5 underrun flag", urun, !VEC[i][32]);
      chk(rdy == 1'b1, "R2 ready at frame start", rdy, 1);
    end

    // R7: idle beats after a word, rxBit high
    bad = 1'b0;
    for (int k = 0; k < 4; k++) begin
      doBeat(1'b0, 1'b1);
      if (txBit !== 1'b0 || rxValid !== 1'b0 || readySeen !== 1'b0) bad = 1'b1;
    end
    chk(!bad, "R7 idle line low, rx ignored, R2 no ready", bad, 0);

    // R6: early frame marker
    txValid = 1'b1;
    txData = 16'hDEAD;
    doBeat(1'b1, 1'b1);
    txValid = 1'b0;
    bad = 1'b0;
    for (int k = 0; k < 4; k++) begin
      doBeat(1'b0, 1'b1);
      if (rxValid) bad = 1'b1;
    end
    runWord(1'b1, 16'h3C5A, 16'h0F0F, txCap, rxGot, gotValid, earlyValid, urun, rdy);
    chk(!bad && !earlyValid, "R6 partial word dropped", {bad, earlyValid}, 0);
    chk(gotValid && rxGot == 16'h0F0F, "R6 rx restart", rxGot, 16'h0F0F);
    chk(txCap == 16'h3C5A, "R6 tx restart", txCap, 16'h3C5A);

    // R8: frameSync without bitEn ignored
    txValid = 1'b1;
    txData = 16'h8000;
    doBeat(1'b1, 1'b0);
    chk(txBit == 1'b1, "R3 first bit", txBit, 1);
    bad = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      frameSync = 1'b1;
      rxBit = 1'b1;
      #1 if (txReady) bad = 1'b1;
      @(negedge clk);
      if (txBit !== 1'b1) bad = 1'b1;
    end
    frameSync = 1'b0;
    txValid = 1'b0;
    chk(!bad, "R8 no-beat cycles ignored", bad, 0);
    doBeat(1'b0, 1'b0);
    chk(txBit == 1'b0 && underrun == 1'b0, "R8 shift continued", {txBit, underrun}, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule